// File: doc/BRIEF.md
# Store Byte-Lane Alignment Unit

This block sits at the end of the address stage of a 64-bit load/store pipeline. It turns one store request into a memory write. The request carries a base register, a signed 16-bit displacement, the register data and a size code. The block forms the effective address and applies the two endianness controls to the address and to the byte-lane choice. It then shifts the data onto the correct lanes of the 64-bit write bus and produces one enable bit per byte. Address translation is an identity pass-through.

A store-conditional request is gated by the current link bit. It must be aligned to its own size; if it is not, the block raises a one-cycle alignment-fault pulse and performs neither the memory write nor the register writeback. An aligned conditional store writes memory only when the link bit is set, and in both cases it returns the link bit as the value for the data register. Every output is registered, one cycle after the request. A parameter selects the wide mode (three lane-index bits) or the narrow mode (two lane-index bits).

Top module: `store_lane_align`

## Requirements
- R1: The effective address is the base plus the displacement sign-extended to the address width. With no endianness flags set, a plain store presents it unchanged as the memory address.
- R2: Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. For a little-endian CPU the lane index is the effective address's low lane bits with the bits below the access size cleared. The enables are that many consecutive ones starting at the lane index (bit k = byte k, data bits 8k+7:8k). The write data is the store data shifted left by eight times the lane index.
- R3: With the big-endian CPU flag set, the lane index of R2 is additionally XORed with the lane-bit mask restricted to the bits at or above the access size.
- R4: With reverse-endian set, a plain store inverts every lane bit of the address: bits 2:0 in wide mode, bits 1:0 in narrow mode.
- R5: With reverse-endian set, a conditional store inverts only the lane bits at or above its access size. A word therefore flips bit 2, and a doubleword flips nothing.
- R6: With the big-endian memory flag set, the address bits below the access size are cleared after the reverse-endian inversion.
- R7: A conditional store whose effective address is not a multiple of its size gives a fault pulse lasting exactly one cycle. It gives no write strobe, no enables and no writeback.
- R8: An aligned conditional store raises the write strobe only when the link bit is 1. It always gives a writeback pulse whose 64-bit value is the link bit (1 or 0).
- R9: All outputs appear one clock after the request. In a cycle after no request, the write strobe, fault, writeback and enables are all 0, as they are after reset.
- R10: The write strobe and the fault pulse are never high in the same cycle.
- R11: In narrow mode the lane index has two bits (mask 3), so big-endian lane flipping stays within the low four lanes.
- R12: A plain (non-conditional) store always writes, whatever its alignment and link bit, and never faults or writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Store request present this cycle |
| base_addr | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| st_data | input | 64 | Register data to store |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| rev_endian | input | 1 | Reverse-endian mode |
| cpu_big | input | 1 | CPU is big-endian |
| mem_big | input | 1 | Memory is big-endian |
| is_cond | input | 1 | Request is a store-conditional |
| link_bit | input | 1 | Current link bit |
| mem_addr | output | 64 | Physical write address |
| mem_wdata | output | 64 | Lane-shifted write data |
| mem_be | output | 8 | Byte enables |
| mem_we | output | 1 | Write strobe |
| align_fault | output | 1 | Unaligned conditional-store pulse |
| wb_valid | output | 1 | Conditional-store writeback pulse |
| wb_data | output | 64 | Writeback value (link bit) |

## Verification
The lane logic is tried with every size at several address offsets and with both CPU byte orders. These cases separate a correct lane XOR from one that flips the wrong bits or ignores the size. Reverse-endian cases are repeated for plain and conditional stores of the same size, which tells the full-mask inversion apart from the size-limited one. Memory-big cases on odd addresses show whether the clear happens after the inversion. Conditional stores are tried misaligned, aligned with link set and aligned with link clear, against a plain store with link clear. A narrow-mode instance receives the same stimulus, which shows that its lane mask is two bits wide.

// File: rtl/sba_pkg.sv
package sba_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } sba_size_e;

   // bits below the access size: 0, 1, 3, 7
   function automatic logic [2:0] size_low_bits(logic [1:0] s);
      logic [3:0] m;
      m = (4'd1 << s) - 4'd1;
      return m[2:0];
   endfunction

   function automatic logic [3:0] size_bytes(logic [1:0] s);
      return 4'd1 << s;
   endfunction
endpackage

// File: rtl/sba_addr_gen.sv
module sba_addr_gen
   import sba_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter bit WIDE   = 1'b1
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [15:0]       disp_i,
   input  logic [1:0]        size_i,
   input  logic              rev_i,
   input  logic              cpu_big_i,
   input  logic              mem_big_i,
   input  logic              cond_i,
   output logic [ADDR_W-1:0] paddr_o,
   output logic [2:0]        lane_o,
   output logic              misaligned_o
);
   localparam int EXT_W = ADDR_W - 16;
   localparam int HI_W  = ADDR_W - 3;

   logic [2:0]        lane_mask;
   logic [ADDR_W-1:0] eff;
   logic [2:0]        low_bits;
   logic [2:0]        upper_bits;
   logic [2:0]        flip;
   logic [ADDR_W-1:0] flipped;

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("sba_addr_gen: ADDR_W must be at least 16");
      end
      if (WIDE) begin : g_wide
         assign lane_mask = 3'b111;
      end else begin : g_narrow
         assign lane_mask = 3'b011;
      end
   endgenerate

   always_comb begin
      eff        = base_i + {{EXT_W{disp_i[15]}}, disp_i};
      low_bits   = size_low_bits(size_i);
      upper_bits = lane_mask & ~low_bits;
      lane_o     = (eff[2:0] & upper_bits) ^ (cpu_big_i ? upper_bits : 3'b000);
      if (!rev_i)
         flip = 3'b000;
      else if (cond_i)
         flip = upper_bits;
      else
         flip = lane_mask;
      flipped = eff ^ {{HI_W{1'b0}}, flip};
      paddr_o = mem_big_i ? (flipped & ~{{HI_W{1'b0}}, low_bits}) : flipped;
      misaligned_o = cond_i && (|(eff[2:0] & low_bits));
   end
endmodule

// File: rtl/sba_lane_shift.sv
module sba_lane_shift
   import sba_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]   data_i,
   input  logic [1:0]          size_i,
   input  logic [2:0]          lane_i,
   output logic [DATA_W-1:0]   wdata_o,
   output logic [DATA_W/8-1:0] be_o
);
   localparam int LANES = DATA_W / 8;

   logic [3:0] nbytes;
   logic [3:0] lane_lo;
   logic [3:0] lane_hi;

   assign nbytes  = size_bytes(size_i);
   assign lane_lo = {1'b0, lane_i};
   assign lane_hi = lane_lo + nbytes;
   assign wdata_o = data_i << {lane_i, 3'b000};

   generate
      if (DATA_W != 64) begin : g_bad_data
         $error("sba_lane_shift: DATA_W must be 64");
      end
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign be_o[k] = (lane_lo <= 4'(k)) && (4'(k) < lane_hi);
      end
   endgenerate

   always_comb begin
      if (!$isunknown({size_i, lane_i}) && (lane_hi <= 4'd8))
         p_be_count_r2: assert ($countones(be_o) == 32'(nbytes));
   end
endmodule

// File: rtl/sba_cond_ctl.sv
module sba_cond_ctl (
   input  logic req_i,
   input  logic cond_i,
   input  logic link_i,
   input  logic misaligned_i,
   output logic we_o,
   output logic fault_o,
   output logic wb_o
);
   assign we_o    = req_i && !misaligned_i && (!cond_i || link_i);
   assign fault_o = req_i && misaligned_i;
   assign wb_o    = req_i && cond_i && !misaligned_i;

   always_comb begin
      if (!$isunknown({req_i, cond_i, misaligned_i}))
         p_plain_nofault_r12: assert (!(fault_o && !cond_i));
   end
endmodule

// File: rtl/store_lane_align.sv
module store_lane_align
   import sba_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter bit WIDE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   base_addr,
   input  logic [15:0]         disp,
   input  logic [DATA_W-1:0]   st_data,
   input  logic [1:0]          st_size,
   input  logic                rev_endian,
   input  logic                cpu_big,
   input  logic                mem_big,
   input  logic                is_cond,
   input  logic                link_bit,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [DATA_W/8-1:0] mem_be,
   output logic                mem_we,
   output logic                align_fault,
   output logic                wb_valid,
   output logic [DATA_W-1:0]   wb_data
);
   localparam int BE_W = DATA_W / 8;

   logic [ADDR_W-1:0] paddr_c;
   logic [2:0]        lane_c;
   logic              mis_c;
   logic [DATA_W-1:0] wdata_c;
   logic [BE_W-1:0]   be_c;
   logic              we_c;
   logic              fault_c;
   logic              wb_c;

   sba_addr_gen #(.ADDR_W(ADDR_W), .WIDE(WIDE)) u_addr (
      .base_i      (base_addr),
      .disp_i      (disp),
      .size_i      (st_size),
      .rev_i       (rev_endian),
      .cpu_big_i   (cpu_big),
      .mem_big_i   (mem_big),
      .cond_i      (is_cond),
      .paddr_o     (paddr_c),
      .lane_o      (lane_c),
      .misaligned_o(mis_c)
   );

   sba_lane_shift #(.DATA_W(DATA_W)) u_shift (
      .data_i (st_data),
      .size_i (st_size),
      .lane_i (lane_c),
      .wdata_o(wdata_c),
      .be_o   (be_c)
   );

   sba_cond_ctl u_ctl (
      .req_i       (req_valid),
      .cond_i      (is_cond),
      .link_i      (link_bit),
      .misaligned_i(mis_c),
      .we_o        (we_c),
      .fault_o     (fault_c),
      .wb_o        (wb_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr    <= '0;
         mem_wdata   <= '0;
         mem_be      <= '0;
         mem_we      <= 1'b0;
         align_fault <= 1'b0;
         wb_valid    <= 1'b0;
         wb_data     <= '0;
      end else begin
         mem_we      <= we_c;
         align_fault <= fault_c;
         wb_valid    <= wb_c;
         mem_be      <= we_c ? be_c : '0;
         if (req_valid) begin
            mem_addr  <= paddr_c;
            mem_wdata <= wdata_c;
            wb_data   <= {{(DATA_W-1){1'b0}}, link_bit};
         end
      end
   end

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && align_fault));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!mem_we && !align_fault && !wb_valid && mem_be == '0));

   p_nolink_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_cond && !link_bit) |=> !mem_we);

   p_plain_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !is_cond) |=> (mem_we && !align_fault && !wb_valid));

   p_fault_nowb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> (!wb_valid && mem_be == '0));
endmodule

// File: tb/test_store_lane_align.sv
module test_store_lane_align;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] base_addr = '0;
   logic [15:0] disp = '0;
   logic [63:0] st_data = '0;
   logic [1:0]  st_size = '0;
   logic        rev_endian = 1'b0;
   logic        cpu_big = 1'b0;
   logic        mem_big = 1'b0;
   logic        is_cond = 1'b0;
   logic        link_bit = 1'b0;

   logic [63:0] w_addr, w_wdata, w_wbd, n_addr, n_wdata, n_wbd;
   logic [7:0]  w_be, n_be;
   logic        w_we, w_flt, w_wb, n_we, n_flt, n_wb;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   store_lane_align i_store_lane_align (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_addr(base_addr),
      .disp(disp), .st_data(st_data), .st_size(st_size), .rev_endian(rev_endian),
      .cpu_big(cpu_big), .mem_big(mem_big), .is_cond(is_cond), .link_bit(link_bit),
      .mem_addr(w_addr), .mem_wdata(w_wdata), .mem_be(w_be), .mem_we(w_we),
      .align_fault(w_flt), .wb_valid(w_wb), .wb_data(w_wbd)
   );

   store_lane_align #(.WIDE(1'b0)) i_store_lane_align_narrow (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_addr(base_addr),
      .disp(disp), .st_data(st_data), .st_size(st_size), .rev_endian(rev_endian),
      .cpu_big(cpu_big), .mem_big(mem_big), .is_cond(is_cond), .link_bit(link_bit),
      .mem_addr(n_addr), .mem_wdata(n_wdata), .mem_be(n_be), .mem_we(n_we),
      .align_fault(n_flt), .wb_valid(n_wb), .wb_data(n_wbd)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one request, then both instances compared against the requirement model
   task automatic apply(input string req, input logic [63:0] b, input logic [15:0] d,
                        input logic [63:0] data, input logic [1:0] sz,
                        input logic rv, input logic cb, input logic mb,
                        input logic cd, input logic lk);
      logic [2:0]  lm, lo, up, lane, flip;
      logic [63:0] ea, ad, wd;
      logic [7:0]  be;
      logic        mis, we, wb;
      string       tag;
      @(negedge clk);
      base_addr = b; disp = d; st_data = data; st_size = sz;
      rev_endian = rv; cpu_big = cb; mem_big = mb; is_cond = cd; link_bit = lk;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int m = 0; m < 2; m++) begin
         lm   = (m == 0) ? 3'b111 : 3'b011;
         tag  = (m == 0) ? req : {req, "/R11"};
         lo   = 3'((4'd1 << sz) - 4'd1);
         up   = lm & ~lo;
         ea   = b + {{48{d[15]}}, d};
         lane = (ea[2:0] & up) ^ (cb ? up : 3'b000);
         flip = !rv ? 3'b000 : (cd ? up : lm);
         ad   = ea ^ {61'd0, flip};
         if (mb) ad = ad & ~{61'd0, lo};
         mis  = cd && (|(ea[2:0] & lo));
         we   = !mis && (!cd || lk);
         wb   = cd && !mis;
         be   = we ? 8'(((9'd1 << (4'd1 << sz)) - 9'd1) << lane) : 8'd0;
         wd   = data << (8 * lane);
         if (m == 0) begin
            chk(tag, "we", {63'd0, w_we}, {63'd0, we});
            chk(tag, "fault", {63'd0, w_flt}, {63'd0, mis});
            chk(tag, "wb", {63'd0, w_wb}, {63'd0, wb});
            chk(tag, "be", {56'd0, w_be}, {56'd0, be});
            if (we) begin
               chk(tag, "addr", w_addr, ad);
               chk(tag, "wdata", w_wdata, wd);
            end
            if (wb) chk(tag, "wbdata", w_wbd, {63'd0, lk});
         end else begin
            chk(tag, "we", {63'd0, n_we}, {63'd0, we});
            chk(tag, "fault", {63'd0, n_flt}, {63'd0, mis});
            chk(tag, "be", {56'd0, n_be}, {56'd0, be});
            if (we) begin
               chk(tag, "addr", n_addr, ad);
               chk(tag, "wdata", n_wdata, wd);
            end
         end
      end
   endtask

   task automatic t_reset;
      chk("R9", "reset we", {63'd0, w_we}, 64'd0);
      chk("R9", "reset fault", {63'd0, w_flt}, 64'd0);
      chk("R9", "reset wb", {63'd0, w_wb}, 64'd0);
      chk("R9", "reset be", {56'd0, w_be}, 64'd0);
   endtask

   task automatic t_idle;
      @(negedge clk);
      chk("R9", "idle we", {63'd0, w_we}, 64'd0);
      chk("R9", "idle fault", {63'd0, w_flt}, 64'd0);
      chk("R9", "idle wb", {63'd0, w_wb}, 64'd0);
      chk("R9", "idle be", {56'd0, w_be}, 64'd0);
   endtask

   task automatic t_plain_little;
      apply("R1", 64'h1000, 16'h0005, 64'h00000000000000A5, 2'd0, 0, 0, 0, 0, 0);
      chk("R2", "byte lane5 be", {56'd0, w_be}, 64'h20);
      apply("R1", 64'h2000, 16'hFFF8, 64'hDEAD_BEEF_0123_4567, 2'd3, 0, 0, 0, 0, 0);
      chk("R1", "negative disp addr", w_addr, 64'h1FF8);
      apply("R2", 64'h3000, 16'h0002, 64'h0000_0000_0000_BEEF, 2'd1, 0, 0, 0, 0, 0);
      apply("R2", 64'h3000, 16'h0004, 64'h0000_0000_CAFE_F00D, 2'd2, 0, 0, 0, 0, 0);
      chk("R2", "word upper be", {56'd0, w_be}, 64'hF0);
      apply("R2", 64'h3000, 16'h0007, 64'h0000_0000_0000_1234, 2'd1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_big_cpu;
      apply("R3", 64'h4000, 16'h0001, 64'h77, 2'd0, 0, 1, 0, 0, 0);
      chk("R3", "byte lane6 be", {56'd0, w_be}, 64'h40);
      apply("R3", 64'h4000, 16'h0002, 64'hABCD, 2'd1, 0, 1, 0, 0, 0);
      chk("R3", "half lane4 be", {56'd0, w_be}, 64'h30);
      apply("R3", 64'h4000, 16'h0000, 64'h1122_3344, 2'd2, 0, 1, 0, 0, 0);
      apply("R3", 64'h4008, 16'h0000, 64'h0102_0304_0506_0708, 2'd3, 0, 1, 0, 0, 0);
   endtask

   task automatic t_rev;
      apply("R4", 64'h1000, 16'h0005, 64'h5A, 2'd0, 1, 0, 0, 0, 0);
      chk("R4", "byte addr", w_addr, 64'h1002);
      apply("R4", 64'h1000, 16'h0004, 64'h5A5A5A5A, 2'd2, 1, 0, 0, 0, 0);
      apply("R5", 64'h1000, 16'h0004, 64'h5A5A5A5A, 2'd2, 1, 0, 0, 1, 1);
      chk("R5", "cond word addr", w_addr, 64'h1000);
      apply("R5", 64'h1008, 16'h0000, 64'h1, 2'd3, 1, 0, 0, 1, 1);
      chk("R5", "cond dword addr", w_addr, 64'h1008);
   endtask

   task automatic t_mem_big;
      apply("R6", 64'h1000, 16'h0003, 64'h3344, 2'd1, 0, 0, 1, 0, 0);
      chk("R6", "half addr", w_addr, 64'h1002);
      apply("R6", 64'h1000, 16'h0006, 64'h55667788, 2'd2, 1, 0, 1, 0, 0);
      chk("R6", "rev then clear", w_addr, 64'h1000);
   endtask

   task automatic t_cond;
      apply("R7", 64'h1000, 16'h0002, 64'h99, 2'd2, 0, 0, 0, 1, 1);
      chk("R7", "word fault", {63'd0, w_flt}, 64'd1);
      @(negedge clk);
      chk("R7", "fault one cycle", {63'd0, w_flt}, 64'd0);
      apply("R7", 64'h1000, 16'h0004, 64'h99, 2'd3, 0, 0, 0, 1, 1);
      apply("R8", 64'h1000, 16'h0008, 64'hFEED, 2'd3, 0, 0, 0, 1, 1);
      chk("R8", "link set wbdata", w_wbd, 64'd1);
      apply("R8", 64'h1000, 16'h0004, 64'hFEED, 2'd2, 0, 1, 0, 1, 0);
      chk("R8", "link clear we", {63'd0, w_we}, 64'd0);
      chk("R10", "no fault with aligned", {63'd0, w_flt}, 64'd0);
      apply("R12", 64'h1000, 16'h0003, 64'hBEEF, 2'd2, 0, 0, 0, 0, 0);
      chk("R12", "plain writes", {63'd0, w_we}, 64'd1);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain_little();
      t_idle();
      t_big_cpu();
      t_rev();
      t_mem_big();
      t_cond();
      t_idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule